// File: doc/BRIEF.md
# Bit-Packing Sample Byte Queue

This block takes a burst of measurement samples whose width is set at run time and writes them into a byte queue as one continuous bit stream. Sample bits go in least significant bit first, with no gap between samples. When the burst ends, any partly filled byte is completed with zeros in its upper bits. If enabled, two status bytes are then added, so they always begin on a byte boundary.

A host drains the queue through a simple read strobe. Each successful read returns the oldest byte one cycle later and lowers the fill level by one. The host first reads the fill level and the error flags. It then reads exactly that many bytes. Two flags are sticky until a clear strobe:
- an overflow flag, set when a byte was dropped because the queue was full;
- an underflow flag, set when the queue was read while empty.

Top module: `sample_byte_packer`

## Requirements
- R1: A sample of width W (cfg_width 1..16; 0 is taken as 16) adds its low W bits to the stream. Sample bit 0 lands at the next free stream bit, and bytes fill from bit 0 upward. Data bits above W are ignored.
- R2: A burst holds cfg_count+1 samples. The sample that completes the count ends the burst.
- R3: At burst end, a partially filled byte is pushed with zeros above its last data bit. A burst that ends on a byte boundary pushes no extra byte.
- R4: With cfg_gain_en set, stat_a and then stat_b follow the last data byte. For example, four 16-bit samples put them at stream bytes 8 and 9, and four 11-bit samples put them at bytes 6 and 7.
- R5: With cfg_gain_en clear, the burst adds only its data bytes.
- R6: A byte pushed while the queue holds DEPTH bytes is dropped, and ovf_flag is set. fill_level never exceeds DEPTH, and bytes already stored keep their order.
- R7: rd_strobe with fill_level non-zero puts the oldest byte on rd_data on the next cycle and lowers fill_level by one.
- R8: rd_strobe with fill_level zero puts 0x00 on rd_data on the next cycle, sets unf_flag, and leaves fill_level at zero.
- R9: ovf_flag and unf_flag stay set until err_clear. err_clear clears both on the next cycle and takes priority over a new error in the same cycle.
- R10: smp_valid is ignored during the closing cycles that follow a burst: one cycle without status bytes, two cycles with them.
- R11: After reset, fill_level is 0, both flags are clear and rd_data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | SMP_W | Sample value, low bits used |
| cfg_width | input | $clog2(SMP_W+1) | Sample width in bits |
| cfg_count | input | CNT_W | Samples per burst minus one |
| cfg_gain_en | input | 1 | Append the two status bytes |
| stat_a | input | 8 | First status byte |
| stat_b | input | 8 | Second status byte |
| rd_strobe | input | 1 | Pop one byte |
| err_clear | input | 1 | Clear both sticky flags |
| rd_data | output | 8 | Byte returned by the previous read |
| fill_level | output | $clog2(DEPTH+1) | Bytes held in the queue |
| ovf_flag | output | 1 | Sticky: bytes were dropped |
| unf_flag | output | 1 | Sticky: read while empty |

## Verification
A wrong bit count left in the accumulator moves every later sample bit. It shows on the first byte the host pops after that sample, and it also changes the byte count read from fill_level once the burst closes. A wrong sample counter or closing state shows as a fill_level off by one or two status bytes on the cycle after the burst ends. A wrong queue pointer or level shows on rd_data or fill_level one cycle after the read strobe that touches it.

// File: rtl/sbp_pkg.sv
`timescale 1ns/1ps
package sbp_pkg;

    typedef enum logic [1:0] {
        PK_COLLECT = 2'd0,
        PK_PAD     = 2'd1,
        PK_STATUS  = 2'd2
    } pk_state_e;

    // bytes that may leave the packer in one cycle: leftover (<8) + one sample,
    // and never fewer than the two status bytes
    function automatic int bytes_per_cycle(input int smp_w);
        int n;
        n = (smp_w + 7) / 8;
        return (n < 2) ? 2 : n;
    endfunction

endpackage

// File: rtl/bit_packer.sv
`timescale 1ns/1ps
module bit_packer
    import sbp_pkg::*;
#(
    parameter int SMP_W = 16,
    parameter int CNT_W = 4,
    parameter int NP    = bytes_per_cycle(SMP_W)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          smp_valid,
    input  logic [SMP_W-1:0]              smp_data,
    input  logic [$clog2(SMP_W+1)-1:0]    cfg_width,
    input  logic [CNT_W-1:0]              cfg_count,
    input  logic                          cfg_gain_en,
    input  logic [7:0]                    stat_a,
    input  logic [7:0]                    stat_b,
    output logic [NP-1:0]                 push_en,
    output logic [NP-1:0][7:0]            push_byte
);
    localparam int WW  = $clog2(SMP_W + 1);
    localparam int AW0 = SMP_W + 7;
    localparam int AW  = (AW0 > 8 * NP) ? AW0 : 8 * NP;
    localparam int NBW = $clog2(AW + 1);

    typedef struct packed {
        pk_state_e        st;
        logic [AW-1:0]    acc;
        logic [NBW-1:0]   nb;
        logic [CNT_W-1:0] cnt;
    } pk_reg_t;

    pk_reg_t q, d;

    logic [7:0]    wid;
    logic [AW-1:0] mask;
    logic [AW-1:0] comb;
    logic [7:0]    tot_w;
    logic [7:0]    nfull;

    always_comb begin
        d         = q;
        push_en   = '0;
        push_byte = '0;
        wid       = ((cfg_width == '0) || (cfg_width > WW'(SMP_W))) ? 8'(SMP_W) : 8'(cfg_width);
        mask      = {AW{1'b1}} >> (AW - int'(wid));
        comb      = q.acc | ((AW'(smp_data) & mask) << q.nb);
        tot_w     = 8'(q.nb) + wid;
        nfull     = tot_w >> 3;
        unique case (q.st)
            PK_COLLECT: begin
                if (smp_valid) begin
                    for (int k = 0; k < NP; k++) begin
                        if (int'(tot_w) >= 8 * (k + 1)) begin
                            push_en[k]   = 1'b1;
                            push_byte[k] = comb[8*k +: 8];
                        end
                    end
                    d.acc = comb >> (nfull * 8);
                    d.nb  = NBW'(tot_w - (nfull << 3));
                    if (q.cnt == cfg_count) begin
                        d.cnt = '0;
                        d.st  = PK_PAD;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            PK_PAD: begin
                if (q.nb != '0) begin
                    push_en[0]   = 1'b1;
                    push_byte[0] = q.acc[7:0];
                end
                d.acc = '0;
                d.nb  = '0;
                d.st  = cfg_gain_en ? PK_STATUS : PK_COLLECT;
            end
            PK_STATUS: begin
                push_en[0]   = 1'b1;
                push_byte[0] = stat_a;
                push_en[1]   = 1'b1;
                push_byte[1] = stat_b;
                d.st         = PK_COLLECT;
            end
            default: d.st = PK_COLLECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: PK_COLLECT, acc: '0, nb: '0, cnt: '0};
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/byte_fifo.sv
`timescale 1ns/1ps
module byte_fifo #(
    parameter int DEPTH = 32,
    parameter int NP    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NP-1:0]               push_en,
    input  logic [NP-1:0][7:0]          push_byte,
    input  logic                        rd_strobe,
    input  logic                        err_clear,
    output logic [7:0]                  rd_data,
    output logic [$clog2(DEPTH+1)-1:0]  level,
    output logic                        ovf,
    output logic                        unf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [LW-1:0] lvl;
        logic          ovf;
        logic          unf;
        logic [7:0]    rdata;
    } ff_reg_t;

    ff_reg_t q, d;

    logic [7:0]            mem [DEPTH];
    logic [NP-1:0]         wen;
    logic [NP-1:0][PW-1:0] waddr;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d     = q;
        wen   = '0;
        waddr = '0;
        if (rd_strobe) begin
            if (q.lvl != '0) begin
                d.rdata = mem[q.rptr];
                d.rptr  = ptr_inc(q.rptr);
                d.lvl   = q.lvl - 1'b1;
            end else begin
                d.rdata = 8'h00;
                d.unf   = 1'b1;
            end
        end
        for (int k = 0; k < NP; k++) begin
            if (push_en[k]) begin
                if (d.lvl < LW'(DEPTH)) begin
                    wen[k]   = 1'b1;
                    waddr[k] = d.wptr;
                    d.wptr   = ptr_inc(d.wptr);
                    d.lvl    = d.lvl + 1'b1;
                end else begin
                    d.ovf = 1'b1;
                end
            end
        end
        if (err_clear) begin
            d.ovf = 1'b0;
            d.unf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NP; k++) begin
            if (wen[k]) begin
                mem[waddr[k]] <= push_byte[k];
            end
        end
    end

    assign rd_data = q.rdata;
    assign level   = q.lvl;
    assign ovf     = q.ovf;
    assign unf     = q.unf;

endmodule

// File: rtl/sample_byte_packer.sv
`timescale 1ns/1ps
module sample_byte_packer
    import sbp_pkg::*;
#(
    parameter int SMP_W = 16,
    parameter int CNT_W = 4,
    parameter int DEPTH = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          smp_valid,
    input  logic [SMP_W-1:0]              smp_data,
    input  logic [$clog2(SMP_W+1)-1:0]    cfg_width,
    input  logic [CNT_W-1:0]              cfg_count,
    input  logic                          cfg_gain_en,
    input  logic [7:0]                    stat_a,
    input  logic [7:0]                    stat_b,
    input  logic                          rd_strobe,
    input  logic                          err_clear,
    output logic [7:0]                    rd_data,
    output logic [$clog2(DEPTH+1)-1:0]    fill_level,
    output logic                          ovf_flag,
    output logic                          unf_flag
);
    localparam int NP = bytes_per_cycle(SMP_W);

    logic [NP-1:0]      push_en;
    logic [NP-1:0][7:0] push_byte;

    bit_packer #(
        .SMP_W (SMP_W),
        .CNT_W (CNT_W),
        .NP    (NP)
    ) packer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .cfg_width   (cfg_width),
        .cfg_count   (cfg_count),
        .cfg_gain_en (cfg_gain_en),
        .stat_a      (stat_a),
        .stat_b      (stat_b),
        .push_en     (push_en),
        .push_byte   (push_byte)
    );

    byte_fifo #(
        .DEPTH (DEPTH),
        .NP    (NP)
    ) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_byte (push_byte),
        .rd_strobe (rd_strobe),
        .err_clear (err_clear),
        .rd_data   (rd_data),
        .level     (fill_level),
        .ovf       (ovf_flag),
        .unf       (unf_flag)
    );

endmodule

// File: rtl/sbp_checker.sv
`timescale 1ns/1ps
module sbp_checker #(
    parameter int DEPTH = 32,
    parameter int NP    = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        rd_strobe,
    input logic                        err_clear,
    input logic [7:0]                  rd_data,
    input logic [$clog2(DEPTH+1)-1:0]  fill_level,
    input logic                        ovf_flag,
    input logic                        unf_flag,
    input logic [NP-1:0]               push_en
);
    assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill_level) <= DEPTH);

    assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && fill_level == '0 && !err_clear) |=> (unf_flag && rd_data == 8'h00));

    assert_sticky_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !err_clear) |=> ovf_flag);

    assert_sticky_unf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_flag && !err_clear) |=> unf_flag);

    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_clear |=> (!ovf_flag && !unf_flag));

    assert_level_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fill_level) < DEPTH - NP) |=>
        (int'(fill_level) == int'($past(fill_level)) + $countones($past(push_en))
                             - (($past(rd_strobe) && $past(fill_level) != '0) ? 1 : 0)));
endmodule

bind sample_byte_packer sbp_checker #(
    .DEPTH (DEPTH),
    .NP    (NP)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_strobe  (rd_strobe),
    .err_clear  (err_clear),
    .rd_data    (rd_data),
    .fill_level (fill_level),
    .ovf_flag   (ovf_flag),
    .unf_flag   (unf_flag),
    .push_en    (push_en)
);

// File: tb/sample_byte_packer_tb.sv
`timescale 1ns/1ps
module sample_byte_packer_tb_top;
    localparam int SMP_W = 16;
    localparam int CNT_W = 4;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic [4:0]  cfg_width = 5'd16;
    logic [3:0]  cfg_count = '0;
    logic        cfg_gain_en = 1'b0;
    logic [7:0]  stat_a = '0;
    logic [7:0]  stat_b = '0;
    logic        rd_strobe = 1'b0;
    logic        err_clear = 1'b0;
    logic [7:0]  rd_data;
    logic [5:0]  fill_level;
    logic        ovf_flag;
    logic        unf_flag;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] smp [0:15];
    logic [7:0]  exp_b [0:63];
    int          exp_n;

    always #5 clk = ~clk;

    sample_byte_packer #(.SMP_W(SMP_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_width(cfg_width), .cfg_count(cfg_count), .cfg_gain_en(cfg_gain_en),
        .stat_a(stat_a), .stat_b(stat_b), .rd_strobe(rd_strobe), .err_clear(err_clear),
        .rd_data(rd_data), .fill_level(fill_level), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // reference stream built from the requirements (R1, R3, R4)
    task automatic build_exp(input int w, input int cnt, input bit g);
        int bp;
        bp = 0;
        for (int i = 0; i < 64; i++) exp_b[i] = 8'h00;
        for (int s = 0; s <= cnt; s++) begin
            for (int b = 0; b < w; b++) begin
                if (smp[s][b]) exp_b[bp / 8][bp % 8] = 1'b1;
                bp++;
            end
        end
        exp_n = (bp + 7) / 8;
        if (g) begin
            exp_b[exp_n]     = stat_a;
            exp_b[exp_n + 1] = stat_b;
            exp_n += 2;
        end
    endtask

    // drives one burst, then holds smp_valid high through the closing cycles (R10)
    task automatic send_burst(input int w, input int cnt, input bit g);
        cfg_width   = 5'(w);
        cfg_count   = 4'(cnt);
        cfg_gain_en = g;
        for (int i = 0; i <= cnt; i++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_data  = smp[i];
        end
        for (int j = 0; j < (g ? 2 : 1); j++) begin
            @(negedge clk);
            smp_data = 16'hFFFF;
        end
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_byte(output logic [7:0] b);
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        b = rd_data;
    endtask

    task automatic drain(input string req, input int from, input int upto);
        logic [7:0] b;
        for (int i = from; i < upto; i++) begin
            read_byte(b);
            check(req, b, exp_b[i]);
        end
        check("R7 level after drain", fill_level, 0);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 level", fill_level, 0);
        check("R11 ovf", ovf_flag, 0);
        check("R11 unf", unf_flag, 0);
        check("R11 rd_data", rd_data, 0);
    endtask

    task automatic t_full16();
        for (int i = 0; i < 4; i++) smp[i] = 16'hA000 + 16'(i * 16'h0111);
        stat_a = 8'h3C; stat_b = 8'hC3;
        build_exp(16, 3, 1'b1);
        send_burst(16, 3, 1'b1);
        check("R2 R4 level 16-bit burst", fill_level, 10);
        check("R4 byte8 is stat_a", exp_b[8], 8'h3C);
        drain("R1 R4 16-bit stream", 0, 10);
    endtask

    task automatic t_w11();
        smp[0] = 16'hF8A5; smp[1] = 16'h0FFF; smp[2] = 16'h1234; smp[3] = 16'hFD5A;
        stat_a = 8'h81; stat_b = 8'h18;
        build_exp(11, 3, 1'b1);
        send_burst(11, 3, 1'b1);
        check("R3 R4 R10 level 11-bit burst", fill_level, 8);
        check("R3 pad bits zero", exp_b[5] & 8'hF0, 0);
        drain("R1 R3 R4 11-bit stream", 0, 8);
    endtask

    task automatic t_w5_nogain();
        smp[0] = 16'hFFE5; smp[1] = 16'h001B; smp[2] = 16'h7FF6;
        build_exp(5, 2, 1'b0);
        send_burst(5, 2, 1'b0);
        check("R5 R10 level 5-bit no status", fill_level, 2);
        drain("R1 R3 R5 5-bit stream", 0, 2);
    endtask

    task automatic t_w8_aligned();
        smp[0] = 16'hAB5E; smp[1] = 16'h00C7;
        stat_a = 8'h11; stat_b = 8'h22;
        build_exp(8, 1, 1'b1);
        send_burst(8, 1, 1'b1);
        check("R3 no pad byte when aligned", fill_level, 4);
        drain("R3 R4 8-bit stream", 0, 4);
    endtask

    task automatic t_underflow();
        logic [7:0] b;
        read_byte(b);
        check("R8 empty read data", b, 0);
        check("R8 unf set", unf_flag, 1);
        check("R8 level stays 0", fill_level, 0);
        repeat (3) @(negedge clk);
        check("R9 unf sticky", unf_flag, 1);
        pulse_clear();
        check("R9 unf cleared", unf_flag, 0);
    endtask

    task automatic t_overflow();
        logic [7:0] b;
        for (int i = 0; i < 16; i++) smp[i] = 16'h1357 + 16'(i * 16'h0F1D);
        stat_a = 8'h99; stat_b = 8'h66;
        build_exp(16, 15, 1'b1);
        send_burst(16, 15, 1'b1);
        check("R6 level saturates", fill_level, DEPTH);
        check("R6 ovf set", ovf_flag, 1);
        read_byte(b);
        check("R6 R7 oldest byte kept", b, exp_b[0]);
        check("R7 level dec", fill_level, DEPTH - 1);
        check("R9 ovf sticky", ovf_flag, 1);
        pulse_clear();
        check("R9 ovf cleared", ovf_flag, 0);
        drain("R6 order after drop", 1, DEPTH);
        check("R6 no underflow", unf_flag, 0);
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=running expected=done");
                $display("test done: total=%0d bad=%0d", n_chk, n_bad);
                $finish;
            end
        join_none
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full16();
        t_w11();
        t_w5_nogain();
        t_w8_aligned();
        t_underflow();
        t_overflow();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule